// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits on the device side of a multi-bank parallel NOR flash. It interprets the stream of bus write cycles. Each cycle is an address and a data word. The block recognizes the unlock-prefixed command sequences and the short single-write commands.

When a program or erase sequence completes, it emits a one-clock operation strobe together with the latched target address, data or sector number. An external algorithm stub carries out the operation and reports progress on a single `busy` level.

The block also reports the interface mode. Mode decides how later reads are served: array data, identification data, query table, erase-suspended array, or the shortened unlock-bypass command set. The suspend and resume commands are accepted only in the right mode and operation context. The same holds for reset and query entry.

All write matching uses only address bits 11:0 and data bits 7:0. The autoselect bank comes from the top three address bits. The erase sector number comes from address bits above bit 11.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0 (array read) and every strobe output is low. Mode encoding: 0 array read, 1 autoselect, 2 query, 3 erase-suspend, 4 unlock-bypass.
- R2: Command and unlock writes are matched on address bits 11:0 and data bits 7:0 only. Set higher address and data bits do not stop a match.
- R3: The four-write program sequence completes with a `prog_stb` pulse of exactly one clock. The sequence is AA at 0x555, 55 at 0x2AA, A0 at 0x555, then the data word at the target. The pulse comes in the clock after the last write. `prog_addr`/`prog_data` hold that write's full address and data.
- R4: The six-write erase sequence pulses `chip_erase_stb` when its last write is 10 at 0x555. The sequence is the unlock pair, 80 at 0x555, then the unlock pair again. If the last write is 30 at any address, the sequence pulses `sect_erase_stb` instead and `erase_sector` takes address bits 22:12.
- R5: A write that does not fit the sequence in progress discards it. If that write is itself AA at 0x555, it starts a new sequence. A complete sequence is always accepted afterwards.
- R6: Writing F0 returns to mode 0, or to mode 3 while an erase is suspended. It acts in array, autoselect, query and erase-suspend modes. In the program data slot, F0 is just data.
- R7: B0 at any address gives a `suspend_stb` pulse and mode 3. This is accepted only while `busy` is high and the last launched operation was a sector erase. 30 at any address gives a `resume_stb` pulse and mode 0, accepted only in mode 3. At other times both are ignored.
- R8: 98 at address 0x055 enters mode 2 only from mode 0 or mode 1. Elsewhere it is not a query entry.
- R9: The unlock pair followed by 90 at 0x555 enters mode 1. `asel_bank` takes address bits 22:20 of that write.
- R10: The unlock pair followed by 20 at 0x555 enters mode 4. In mode 4, A0 then a data write gives `prog_stb`, and 80 then 10 gives `chip_erase_stb`, at any addresses.
- R11: Mode 4 is left only by 90 followed by 00, at any addresses. F0 and other writes leave mode 4 unchanged.
- R12: While `busy` is high, every write other than an accepted suspend is ignored. Mode and partial sequences are unchanged.
- R13: In mode 3, program sequences and autoselect entry are accepted. Erase sequences and bypass entry are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | External algorithm stub is executing an operation |
| prog_stb | output | 1 | One-clock program request |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | DATA_W | Latched program data |
| chip_erase_stb | output | 1 | One-clock whole-array erase request |
| sect_erase_stb | output | 1 | One-clock sector erase request |
| erase_sector | output | ADDR_W-SECT_LSB | Latched sector number |
| suspend_stb | output | 1 | One-clock erase suspend request |
| resume_stb | output | 1 | One-clock erase resume request |
| mode | output | 3 | Current interface mode (encoding in R1) |
| asel_bank | output | BANK_W | Bank selected for autoselect |

## Verification
Sequences are driven with clean low addresses first. They are then repeated with junk in the upper address and data bits, which tells real 12-bit/8-bit matching apart from full-width compares. Sequences broken mid-way are followed by complete ones, including a break that is itself a fresh unlock write; this separates a decoder that recovers from one that sticks or loses the restart. The same command bytes (F0, 30, B0, 98) are sent in different modes and with `busy` high or low. This shows that their effect depends on mode and operation context and not on the byte alone. The bypass short forms are tried next to the reset and faulty exit writes that must not leave bypass.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int CMP_AW = 12;
  localparam int CMP_DW = 8;

  typedef enum logic [2:0] {
    M_ARRAY = 3'd0,
    M_ASEL  = 3'd1,
    M_CFI   = 3'd2,
    M_ESUSP = 3'd3,
    M_BYP   = 3'd4
  } mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3,
    S_BPROG, S_BERASE, S_BEXIT
  } seq_e;

  localparam logic [CMP_DW-1:0] C_UNL1  = 8'hAA;
  localparam logic [CMP_DW-1:0] C_UNL2  = 8'h55;
  localparam logic [CMP_DW-1:0] C_PROG  = 8'hA0;
  localparam logic [CMP_DW-1:0] C_ERASE = 8'h80;
  localparam logic [CMP_DW-1:0] C_CHIP  = 8'h10;
  localparam logic [CMP_DW-1:0] C_SECT  = 8'h30;
  localparam logic [CMP_DW-1:0] C_ASEL  = 8'h90;
  localparam logic [CMP_DW-1:0] C_BYP   = 8'h20;
  localparam logic [CMP_DW-1:0] C_RST   = 8'hF0;
  localparam logic [CMP_DW-1:0] C_SUSP  = 8'hB0;
  localparam logic [CMP_DW-1:0] C_CFI   = 8'h98;
  localparam logic [CMP_DW-1:0] C_BEXIT = 8'h00;

  localparam logic [CMP_AW-1:0] A_CMD = 12'h555;
  localparam logic [CMP_AW-1:0] A_UNL = 12'h2AA;
  localparam logic [CMP_AW-1:0] A_CFI = 12'h055;

  // classified write: flags derived from the compared low fields only
  typedef struct packed {
    logic              unl1;
    logic              unl2;
    logic              at_cmd;
    logic              rst;
    logic              cfi;
    logic              susp;
    logic [CMP_DW-1:0] code;
  } wcls_t;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic susp;
    logic resume;
  } ops_t;

  function automatic logic cyc_is(input logic [CMP_AW-1:0] a, input logic [CMP_DW-1:0] d,
                                  input logic [CMP_AW-1:0] ea, input logic [CMP_DW-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic mode_e reset_target(input logic suspended);
    return suspended ? M_ESUSP : M_ARRAY;
  endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
(
  input  logic [CMP_AW-1:0] lo_addr,
  input  logic [CMP_DW-1:0] lo_data,
  output wcls_t             cls
);
  always_comb begin
    cls.code   = lo_data;
    cls.unl1   = cyc_is(lo_addr, lo_data, A_CMD, C_UNL1);
    cls.unl2   = cyc_is(lo_addr, lo_data, A_UNL, C_UNL2);
    cls.at_cmd = (lo_addr == A_CMD);
    cls.rst    = (lo_data == C_RST);
    cls.cfi    = cyc_is(lo_addr, lo_data, A_CFI, C_CFI);
    cls.susp   = (lo_data == C_SUSP);
  end
endmodule

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
  import fcd_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  wcls_t             cls,
  input  logic [BANK_W-1:0] bank_i,
  output mode_e             mode_q,
  output logic [BANK_W-1:0] bank_q,
  output ops_t              go
);
  seq_e  seq_q, seq_d, restart;
  mode_e mode_d;
  logic  susp_q, susp_d;
  logic  lastsec_q, lastsec_d;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    seq_d     = seq_q;
    mode_d    = mode_q;
    susp_d    = susp_q;
    bank_d    = bank_q;
    go        = '0;
    restart   = cls.unl1 ? S_U1 : S_IDLE;
    if (wr_en) begin
      if (busy) begin
        if (cls.susp && lastsec_q && !susp_q) begin
          go.susp = 1'b1;
          susp_d  = 1'b1;
          mode_d  = M_ESUSP;
          seq_d   = S_IDLE;
        end
      end else begin
        case (mode_q)
          M_ASEL, M_CFI: begin
            if (cls.rst) mode_d = reset_target(susp_q);
            else if (mode_q == M_ASEL && cls.cfi) mode_d = M_CFI;
          end
          M_BYP: begin
            seq_d = S_IDLE;
            case (seq_q)
              S_BPROG:  go.prog = 1'b1;
              S_BERASE: go.chip = (cls.code == C_CHIP);
              S_BEXIT:  if (cls.code == C_BEXIT) mode_d = M_ARRAY;
              default: begin
                if (cls.code == C_PROG)       seq_d = S_BPROG;
                else if (cls.code == C_ERASE) seq_d = S_BERASE;
                else if (cls.code == C_ASEL)  seq_d = S_BEXIT;
              end
            endcase
          end
          default: begin
            if (seq_q == S_PROG) begin
              go.prog = 1'b1;
              seq_d   = S_IDLE;
            end else if (cls.rst) begin
              mode_d = reset_target(susp_q);
              seq_d  = S_IDLE;
            end else if (cls.cfi && mode_q == M_ARRAY) begin
              mode_d = M_CFI;
              seq_d  = S_IDLE;
            end else if (susp_q && cls.code == C_SECT) begin
              go.resume = 1'b1;
              susp_d    = 1'b0;
              mode_d    = M_ARRAY;
              seq_d     = S_IDLE;
            end else begin
              case (seq_q)
                S_U1: seq_d = cls.unl2 ? S_U2 : restart;
                S_U2: begin
                  seq_d = restart;
                  if (cls.at_cmd) begin
                    if (cls.code == C_PROG) seq_d = S_PROG;
                    else if (cls.code == C_ERASE && !susp_q) seq_d = S_E1;
                    else if (cls.code == C_ASEL) begin
                      mode_d = M_ASEL;
                      bank_d = bank_i;
                      seq_d  = S_IDLE;
                    end else if (cls.code == C_BYP && !susp_q) begin
                      mode_d = M_BYP;
                      seq_d  = S_IDLE;
                    end
                  end
                end
                S_E1: seq_d = restart ;
                S_E2: seq_d = cls.unl2 ? S_E3 : restart;
                S_E3: begin
                  seq_d = restart;
                  if (cls.at_cmd && cls.code == C_CHIP) begin
                    go.chip = 1'b1;
                    seq_d   = S_IDLE;
                  end else if (cls.code == C_SECT) begin
                    go.sect = 1'b1;
                    seq_d   = S_IDLE;
                  end
                end
                default: seq_d = restart;
              endcase
              if (seq_q == S_E1 && cls.unl1) seq_d = S_E2;
            end
          end
        endcase
      end
    end
  end

  // remembers whether the running operation may be suspended
  always_comb begin
    lastsec_d = lastsec_q;
    if (go.sect) lastsec_d = 1'b1;
    else if (go.chip || (go.prog && !susp_q)) lastsec_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q     <= S_IDLE;
      mode_q    <= M_ARRAY;
      susp_q    <= 1'b0;
      lastsec_q <= 1'b0;
      bank_q    <= '0;
    end else begin
      seq_q     <= seq_d;
      mode_q    <= mode_d;
      susp_q    <= susp_d;
      lastsec_q <= lastsec_d;
      bank_q    <= bank_d;
    end
  end

  a_r12_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !go.susp) |=> ($stable(mode_q) && $stable(seq_q)));

  a_r7_resume_needs_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    go.resume |-> (susp_q && mode_q == M_ESUSP && !busy));

  a_r7_suspend_needs_erase: assert property (@(posedge clk) disable iff (!rst_n)
    go.susp |-> (busy && lastsec_q));

  a_r11_bypass_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_BYP && mode_d != M_BYP) |-> (wr_en && seq_q == S_BEXIT && cls.code == C_BEXIT));

  a_r8_query_source: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_d == M_CFI && mode_q != M_CFI) |-> (mode_q == M_ARRAY || mode_q == M_ASEL));

  a_r13_no_erase_when_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> !(go.chip || go.sect));

endmodule

// File: rtl/fcd_oplatch.sv
module fcd_oplatch
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int SECT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ops_t              go,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic              prog_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_stb,
  output logic              sect_erase_stb,
  output logic [SECT_W-1:0] erase_sector,
  output logic              suspend_stb,
  output logic              resume_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_stb       <= 1'b0;
      chip_erase_stb <= 1'b0;
      sect_erase_stb <= 1'b0;
      suspend_stb    <= 1'b0;
      resume_stb     <= 1'b0;
      prog_addr      <= '0;
      prog_data      <= '0;
      erase_sector   <= '0;
    end else begin
      prog_stb       <= go.prog;
      chip_erase_stb <= go.chip;
      sect_erase_stb <= go.sect;
      suspend_stb    <= go.susp;
      resume_stb     <= go.resume;
      if (go.prog) begin
        prog_addr <= addr_i;
        prog_data <= data_i;
      end
      if (go.sect) erase_sector <= sect_i;
    end
  end

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb}));

  a_r3_prog_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb);

  a_r4_erase_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase_stb || sect_erase_stb) |=> !(chip_erase_stb || sect_erase_stb));

  a_r3_prog_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !go.prog |=> ($stable(prog_addr) && $stable(prog_data)));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 23,
  parameter int DATA_W   = 16,
  parameter int BANK_W   = 3,
  parameter int SECT_LSB = 12,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              prog_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_stb,
  output logic              sect_erase_stb,
  output logic [SECT_W-1:0] erase_sector,
  output logic              suspend_stb,
  output logic              resume_stb,
  output logic [2:0]        mode,
  output logic [BANK_W-1:0] asel_bank
);
  wcls_t cls;
  ops_t  go;
  mode_e mode_q;

  fcd_classify u_classify (
    .lo_addr (wr_addr[CMP_AW-1:0]),
    .lo_data (wr_data[CMP_DW-1:0]),
    .cls     (cls)
  );

  fcd_sequencer #(.BANK_W(BANK_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .busy   (busy),
    .cls    (cls),
    .bank_i (wr_addr[ADDR_W-1 -: BANK_W]),
    .mode_q (mode_q),
    .bank_q (asel_bank),
    .go     (go)
  );

  fcd_oplatch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_ops (
    .clk            (clk),
    .rst_n          (rst_n),
    .go             (go),
    .addr_i         (wr_addr),
    .data_i         (wr_data),
    .sect_i         (wr_addr[ADDR_W-1:SECT_LSB]),
    .prog_stb       (prog_stb),
    .prog_addr      (prog_addr),
    .prog_data      (prog_data),
    .chip_erase_stb (chip_erase_stb),
    .sect_erase_stb (sect_erase_stb),
    .erase_sector   (erase_sector),
    .suspend_stb    (suspend_stb),
    .resume_stb     (resume_stb)
  );

  assign mode = mode_q;

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [22:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        prog_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb;
  logic [22:0] prog_addr;
  logic [15:0] prog_data;
  logic [10:0] erase_sector;
  logic [2:0]  mode;
  logic [2:0]  asel_bank;

  int n_tests = 0;
  int n_fail  = 0;

  localparam int K_PROG = 0, K_CHIP = 1, K_SECT = 2, K_SUSP = 3, K_RES = 4;

  typedef struct {
    int          kind;
    logic [22:0] addr;
    logic [15:0] data;
    string       req;
  } ev_t;
  ev_t expq[$];

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .prog_stb(prog_stb), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_stb(chip_erase_stb), .sect_erase_stb(sect_erase_stb),
    .erase_sector(erase_sector), .suspend_stb(suspend_stb), .resume_stb(resume_stb),
    .mode(mode), .asel_bank(asel_bank)
  );

  task automatic expect_ev(input int kind, input logic [22:0] a, input logic [15:0] d,
                           input string req);
    ev_t e;
    e.kind = kind; e.addr = a; e.data = d; e.req = req;
    expq.push_back(e);
  endtask

  // monitor: every strobe seen must match the head of the scoreboard queue
  always @(negedge clk) begin
    int kind;
    logic [22:0] act_a;
    logic [15:0] act_d;
    ev_t e;
    if (rst_n) begin
      kind = -1; act_a = '0; act_d = '0;
      if (prog_stb) begin kind = K_PROG; act_a = prog_addr; act_d = prog_data; end
      else if (chip_erase_stb) kind = K_CHIP;
      else if (sect_erase_stb) begin kind = K_SECT; act_a = 23'(erase_sector); end
      else if (suspend_stb) kind = K_SUSP;
      else if (resume_stb) kind = K_RES;
      if (kind >= 0) begin
        n_tests++;
        if (expq.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected strobe (R12/R5 ignored write) actual kind=%0d expected none", kind);
        end else begin
          e = expq.pop_front();
          if (kind != e.kind || act_a !== e.addr || act_d !== e.data) begin
            n_fail++;
            $display("FAIL %s actual kind=%0d addr=%0h data=%0h expected kind=%0d addr=%0h data=%0h",
                     e.req, kind, act_a, act_d, e.kind, e.addr, e.data);
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [22:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unl();
    wr(23'h000555, 16'h00AA);
    wr(23'h0002AA, 16'h0055);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mode after reset", 32'(mode), 0);
    chk("R1 strobes after reset",
        32'({prog_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: plain program
    unl(); wr(23'h000555, 16'h00A0);
    expect_ev(K_PROG, 23'h123456, 16'hBEEF, "R3 program");
    wr(23'h123456, 16'hBEEF);

    // R2 + R6: junk upper bits, F0 as program data
    wr(23'h3AB555, 16'hFFAA); wr(23'h12A2AA, 16'h3355); wr(23'h0F0555, 16'h77A0);
    expect_ev(K_PROG, 23'h000010, 16'hF0F0, "R2 R6 high bits ignored, F0 as data");
    wr(23'h000010, 16'hF0F0);
    chk("R6 F0 data slot keeps mode", 32'(mode), 0);

    // R4: chip and sector erase
    unl(); wr(23'h000555, 16'h0080); unl();
    expect_ev(K_CHIP, '0, '0, "R4 chip erase");
    wr(23'h000555, 16'h0010);
    unl(); wr(23'h000555, 16'h0080); unl();
    expect_ev(K_SECT, 23'(11'h5A3), '0, "R4 sector erase");
    wr(23'h5A3ABC, 16'h0030);

    // R5: broken sequences
    unl(); wr(23'h000555, 16'h0044);
    wr(23'h000555, 16'h00A0); wr(23'h000100, 16'h1111);
    wr(23'h000555, 16'h00AA); wr(23'h000555, 16'h00AA);
    wr(23'h0002AA, 16'h0055); wr(23'h000555, 16'h00A0);
    expect_ev(K_PROG, 23'h000200, 16'h2222, "R5 restart after break");
    wr(23'h000200, 16'h2222);

    // R9 / R8 / R6: autoselect, query, reset
    unl(); wr(23'h600555, 16'h0090);
    chk("R9 autoselect mode", 32'(mode), 1);
    chk("R9 autoselect bank", 32'(asel_bank), 6);
    unl(); wr(23'h000555, 16'h00A0); wr(23'h000300, 16'h3333);
    chk("R9 program ignored in autoselect", 32'(mode), 1);
    wr(23'h000055, 16'h0098);
    chk("R8 query from autoselect", 32'(mode), 2);
    wr(23'h000055, 16'h0098);
    chk("R8 query not re-entered", 32'(mode), 2);
    wr(23'h000777, 16'h00F0);
    chk("R6 reset from query", 32'(mode), 0);
    wr(23'h000056, 16'h0098);
    chk("R8 wrong address no query", 32'(mode), 0);
    wr(23'h000055, 16'h0098);
    chk("R8 query from array", 32'(mode), 2);
    wr(23'h000000, 16'h00F0);
    chk("R6 reset to array", 32'(mode), 0);

    // R10 / R11: unlock bypass
    unl(); wr(23'h000555, 16'h0020);
    chk("R10 bypass entry", 32'(mode), 4);
    wr(23'h012345, 16'h00A0);
    expect_ev(K_PROG, 23'h054321, 16'hCAFE, "R10 bypass program");
    wr(23'h054321, 16'hCAFE);
    wr(23'h000001, 16'h0080);
    expect_ev(K_CHIP, '0, '0, "R10 bypass chip erase");
    wr(23'h000002, 16'h0010);
    wr(23'h000555, 16'h00F0);
    chk("R11 F0 keeps bypass", 32'(mode), 4);
    wr(23'h000003, 16'h0090); wr(23'h000004, 16'h0055);
    chk("R11 bad exit keeps bypass", 32'(mode), 4);
    wr(23'h000003, 16'h0090); wr(23'h000004, 16'h0000);
    chk("R11 bypass exit", 32'(mode), 0);

    // R7 / R12 / R13: suspend and resume
    wr(23'h200000, 16'h0030);
    chk("R7 resume ignored when not suspended", 32'(mode), 0);
    unl(); wr(23'h000555, 16'h0080); unl();
    expect_ev(K_SECT, 23'(11'h200), '0, "R4 sector erase before suspend");
    wr(23'h200123, 16'h0030);
    busy = 1'b1;
    unl(); wr(23'h000555, 16'h00A0); wr(23'h000400, 16'h4444);
    wr(23'h000000, 16'h00F0);
    chk("R12 writes ignored while busy", 32'(mode), 0);
    expect_ev(K_SUSP, '0, '0, "R7 suspend");
    wr(23'h200000, 16'h00B0);
    chk("R7 suspend mode", 32'(mode), 3);
    busy = 1'b0;
    wr(23'h200000, 16'h00B0);
    chk("R7 B0 not busy ignored", 32'(mode), 3);
    unl(); wr(23'h000555, 16'h00A0);
    expect_ev(K_PROG, 23'h000040, 16'h1234, "R13 program in suspend");
    wr(23'h000040, 16'h1234);
    unl(); wr(23'h000555, 16'h0080); unl(); wr(23'h000555, 16'h0010);
    chk("R13 erase refused in suspend", 32'(mode), 3);
    unl(); wr(23'h000555, 16'h0020);
    chk("R13 bypass refused in suspend", 32'(mode), 3);
    unl(); wr(23'h200555, 16'h0090);
    chk("R13 autoselect in suspend", 32'(mode), 1);
    wr(23'h000000, 16'h00F0);
    chk("R6 reset returns to suspend", 32'(mode), 3);
    expect_ev(K_RES, '0, '0, "R7 resume");
    wr(23'h200000, 16'h0030);
    chk("R7 resume mode", 32'(mode), 0);
    busy = 1'b1;
    expect_ev(K_SUSP, '0, '0, "R7 second suspend");
    wr(23'h200000, 16'h00B0);
    chk("R7 second suspend mode", 32'(mode), 3);
    busy = 1'b0;
    expect_ev(K_RES, '0, '0, "R7 second resume");
    wr(23'h200000, 16'h0030);
    unl(); wr(23'h000555, 16'h00A0);
    expect_ev(K_PROG, 23'h000050, 16'h5555, "R3 program before busy");
    wr(23'h000050, 16'h5555);
    busy = 1'b1;
    wr(23'h000000, 16'h00B0);
    chk("R7 suspend refused during program", 32'(mode), 0);
    busy = 1'b0;

    repeat (4) @(negedge clk);
    chk("R3 R4 scoreboard drained", 32'(expq.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule